// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker for Bus-Master Disk DMA

This block walks a table of scatter-gather descriptors in memory on behalf of a bus-master disk DMA engine. Software loads a 32-bit table pointer, picks a transfer direction and sets the run bit. The walker then reads each 8-byte descriptor as two 32-bit words through a simple request/response read port. It hands one (base address, byte count, direction) segment at a time to a downstream data mover and waits for that mover to report the segment finished.

A descriptor holds its control word first and its address word second. The control word carries the byte count in its low 16 bits and an end-of-table marker in bit 31. A count of zero stands for a full 64 KiB. A segment must not run past a 64 KiB address boundary. The walker checks this before it emits anything. When the marked descriptor's segment completes, the walker raises its interrupt flag and drops out of the active state.

Errors have their own paths. A misaligned table pointer is refused before any fetch. A read that returns a bus error, or a descriptor whose segment would cross the boundary, ends the run with both the error and interrupt flags set. Software can abort a run at any time by clearing the run bit.

Top module: `prd_walker`

## Requirements
- R1: After reset the status byte, command byte and table pointer all read zero, the interrupt output is low, and no fetch request or segment is presented.
- R2: For a run started at table pointer P, descriptor k is read as two word requests at addresses P+8k and P+8k+4, in that order. Every request address is 4-byte aligned. A request whose address has not been accepted keeps the same address until it is accepted.
- R3: Each descriptor yields one segment. Its base is the second word, its byte count is control-word bits 15:0, and its direction flag is command bit 3 as written at launch (1 = mover writes memory). The next descriptor is not fetched until the segment-done pulse.
- R4: A control-word count of zero yields a 65536-byte segment. A zero count with a nonzero low half of the base is a boundary error.
- R5: If the low 16 bits of the base plus the byte count exceed 65536, no segment is emitted. Error (status bit 1) and interrupt (status bit 2) are set and active (status bit 0) clears. A segment ending exactly on the boundary is legal.
- R6: When the segment of a descriptor with control-word bit 31 set completes, interrupt is set, error stays clear, active clears and no further fetch is issued.
- R7: Writing the command byte (select 0) with bit 0 set while the stored run bit is 0 starts a run, and active is set on the following cycle. A write with bit 0 set while the run bit is already 1 starts nothing.
- R8: Writing the command byte with bit 0 clear during a run clears active at once. The walker drops any segment and fetch in progress, and does not set interrupt or error.
- R9: A status write (select 1) clears error where data bit 1 is 1 and interrupt where data bit 2 is 1. It loads data bits 5 and 6 into two software-owned capability flags. Active (bit 0) cannot be written.
- R10: Starting with table-pointer bits 1:0 nonzero sets error only. Interrupt stays clear, active stays clear and no fetch is issued.
- R11: A read response flagged as a bus error sets error and interrupt and clears active, and no segment is emitted.
- R12: A table-pointer write (select 2) takes effect only while the walker is not active; during a run it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 command, 1 status, 2 table pointer |
| csr_wdata | input | 32 | Register write data |
| cmd_q | output | 8 | Command byte: bit 0 run, bit 3 direction |
| stat_q | output | 8 | Status byte: bit 0 active, bit 1 error, bit 2 interrupt, bits 6:5 capability flags |
| tbl_ptr_q | output | 32 | Table pointer |
| irq | output | 1 | Interrupt flag level |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read address |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 32 | Read response word |
| mem_rsp_err | input | 1 | Read response carries a bus error |
| seg_valid | output | 1 | Segment presented to the data mover |
| seg_base | output | 32 | Segment base address |
| seg_bytes | output | 17 | Segment length in bytes (1 to 65536) |
| seg_to_mem | output | 1 | Segment direction, 1 = mover writes memory |
| seg_done | input | 1 | Data mover finished the presented segment |

## Verification
The bench builds the walker with its default widths: 32-bit addresses and a 16-bit count field. With these widths the real 64 KiB window is in play. A zero-count descriptor gives a 65536-byte segment, and a segment can end exactly on the boundary or overrun it by a few bytes. Because the data mover is a bench model that only pulses done, full-window segments cost a handful of cycles. The walk, the fault paths and the abort can therefore all be driven at the true boundary values rather than at a scaled-down window.

// File: rtl/prd_pkg.sv
package prd_pkg;

    // walker sequencing states
    typedef enum logic [2:0] {
        W_IDLE,
        W_REQ_LO,
        W_WAIT_LO,
        W_REQ_HI,
        W_WAIT_HI,
        W_CHECK,
        W_SEG
    } walk_state_e;

    // register select codes
    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_PTR  = 2'd2,
        SEL_NONE = 2'd3
    } csr_sel_e;

    // command byte fields
    localparam int CMD_RUN_BIT   = 0;
    localparam int CMD_TOMEM_BIT = 3;

    // status byte fields
    localparam int ST_ACTIVE = 0;
    localparam int ST_ERROR  = 1;
    localparam int ST_IRQ    = 2;
    localparam int ST_CAP_LO = 5;
    localparam int ST_CAP_HI = 6;

    // control word marker of the final descriptor
    localparam int DESC_LAST_BIT = 31;

    // one-cycle events raised by the walker toward the status register
    typedef struct packed {
        logic finish;    // final segment completed
        logic fault;     // bus error or boundary overrun
        logic misalign;  // launch refused for pointer alignment
    } walk_evt_t;

endpackage

// File: rtl/prd_desc_chk.sv
module prd_desc_chk
    import prd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [31:0]       ctl_word,
    input  logic [31:0]       adr_word,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W:0]    bytes,
    output logic              last,
    output logic              overrun
);
    localparam logic [CNT_W:0] SPAN = {1'b1, {CNT_W{1'b0}}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   reach;
    logic             unused_rsvd;

    assign cnt         = ctl_word[CNT_W-1:0];
    assign last        = ctl_word[DESC_LAST_BIT];
    assign base        = adr_word[ADDR_W-1:0];
    assign unused_rsvd = ^ctl_word[DESC_LAST_BIT-1:CNT_W];

    // a zero count stands for the whole window
    assign bytes   = (cnt == '0) ? SPAN : {1'b0, cnt};
    assign reach   = {1'b0, base[CNT_W-1:0]} + bytes;
    assign overrun = reach > SPAN;

endmodule

// File: rtl/prd_seq.sv
module prd_seq
    import prd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              launch_dir,
    input  logic              halt,
    input  logic [ADDR_W-1:0] tbl_ptr,
    output logic              busy,
    output walk_evt_t         evt,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              seg_valid,
    output logic [ADDR_W-1:0] seg_base,
    output logic [CNT_W:0]    seg_bytes,
    output logic              seg_to_mem,
    input  logic              seg_done
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(8);
    localparam logic [CNT_W:0]    SPAN      = {1'b1, {CNT_W{1'b0}}};

    walk_state_e       st_q;
    logic [ADDR_W-1:0] cur_q;
    logic [31:0]       ctl_q;
    logic [31:0]       adr_q;
    logic              dir_q;

    logic [ADDR_W-1:0] d_base;
    logic [CNT_W:0]    d_bytes;
    logic              d_last;
    logic              d_over;
    logic              misaligned;
    logic              rsp_wait;

    prd_desc_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
        .ctl_word (ctl_q),
        .adr_word (adr_q),
        .base     (d_base),
        .bytes    (d_bytes),
        .last     (d_last),
        .overrun  (d_over)
    );

    assign misaligned = |tbl_ptr[1:0];
    assign rsp_wait   = (st_q == W_WAIT_LO) || (st_q == W_WAIT_HI);

    always_comb begin
        evt.misalign = launch && (st_q == W_IDLE) && misaligned;
        evt.fault    = !halt && ((rsp_wait && mem_rsp_valid && mem_rsp_err) ||
                                 ((st_q == W_CHECK) && d_over));
        evt.finish   = !halt && (st_q == W_SEG) && seg_done && d_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= W_IDLE;
            cur_q <= '0;
            ctl_q <= '0;
            adr_q <= '0;
            dir_q <= 1'b0;
        end else if (halt) begin
            st_q <= W_IDLE;
        end else begin
            unique case (st_q)
                W_IDLE: begin
                    if (launch && !misaligned) begin
                        cur_q <= tbl_ptr;
                        dir_q <= launch_dir;
                        st_q  <= W_REQ_LO;
                    end
                end
                W_REQ_LO: if (mem_req_ready) st_q <= W_WAIT_LO;
                W_WAIT_LO: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            st_q <= W_IDLE;
                        end else begin
                            ctl_q <= mem_rsp_data;
                            st_q  <= W_REQ_HI;
                        end
                    end
                end
                W_REQ_HI: if (mem_req_ready) st_q <= W_WAIT_HI;
                W_WAIT_HI: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            st_q <= W_IDLE;
                        end else begin
                            adr_q <= mem_rsp_data;
                            st_q  <= W_CHECK;
                        end
                    end
                end
                W_CHECK: st_q <= d_over ? W_IDLE : W_SEG;
                W_SEG: begin
                    if (seg_done) begin
                        if (d_last) begin
                            st_q <= W_IDLE;
                        end else begin
                            cur_q <= cur_q + DESC_STEP;
                            st_q  <= W_REQ_LO;
                        end
                    end
                end
                default: st_q <= W_IDLE;
            endcase
        end
    end

    assign busy          = (st_q != W_IDLE);
    assign mem_req_valid = (st_q == W_REQ_LO) || (st_q == W_REQ_HI);
    assign mem_req_addr  = (st_q == W_REQ_HI) ? (cur_q + WORD_STEP) : cur_q;
    assign seg_valid     = (st_q == W_SEG);
    assign seg_base      = d_base;
    assign seg_bytes     = d_bytes;
    assign seg_to_mem    = dir_q;

    // R2: request addresses stay on word boundaries
    assert_req_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    // R2: a pending request holds its address until taken
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready && !halt) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R3: fetch and segment phases never overlap
    assert_phase_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_req_valid && seg_valid));

    // R4: presented length lies in 1..window
    assert_len_range_R4: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> ((seg_bytes != '0) && (seg_bytes <= SPAN)));

    // R5: no presented segment leaves its window
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> (({1'b0, seg_base[CNT_W-1:0]} + seg_bytes) <= SPAN));

    // R10: a refused launch issues no fetch
    assert_misalign_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        evt.misalign |=> !mem_req_valid);

endmodule

// File: rtl/prd_csr.sv
module prd_csr
    import prd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [31:0]       wdata,
    input  logic              busy,
    input  walk_evt_t         evt,
    output logic              launch,
    output logic              launch_dir,
    output logic              halt,
    output logic [7:0]        cmd_q,
    output logic [7:0]        stat_q,
    output logic [ADDR_W-1:0] ptr_q
);
    logic       run_q;
    logic       dir_q;
    logic       err_q;
    logic       irq_q;
    logic [1:0] cap_q;
    logic       wr_cmd;
    logic       wr_stat;
    logic       wr_ptr;

    assign wr_cmd  = we && (sel == SEL_CMD);
    assign wr_stat = we && (sel == SEL_STAT);
    assign wr_ptr  = we && (sel == SEL_PTR);

    assign launch     = wr_cmd && wdata[CMD_RUN_BIT] && !run_q;
    assign launch_dir = wdata[CMD_TOMEM_BIT];
    assign halt       = wr_cmd && !wdata[CMD_RUN_BIT] && run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            dir_q <= 1'b0;
            err_q <= 1'b0;
            irq_q <= 1'b0;
            cap_q <= '0;
            ptr_q <= '0;
        end else begin
            if (wr_cmd) begin
                run_q <= wdata[CMD_RUN_BIT];
                dir_q <= wdata[CMD_TOMEM_BIT];
            end
            if (wr_ptr && !busy) ptr_q <= wdata[ADDR_W-1:0];
            if (wr_stat) cap_q <= wdata[ST_CAP_HI:ST_CAP_LO];
            // engine events win over a same-cycle clear
            err_q <= (err_q && !(wr_stat && wdata[ST_ERROR])) || evt.fault || evt.misalign;
            irq_q <= (irq_q && !(wr_stat && wdata[ST_IRQ])) || evt.fault || evt.finish;
        end
    end

    assign cmd_q  = {4'b0000, dir_q, 2'b00, run_q};
    assign stat_q = {1'b0, cap_q, 2'b00, irq_q, err_q, busy};

    // R12: pointer frozen during a run
    assert_ptr_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_ptr) |=> $stable(ptr_q));

    // R6: a completed table leaves interrupt set and the walker idle
    assert_finish_irq_R6: assert property (@(posedge clk) disable iff (rst)
        evt.finish |=> (irq_q && !busy));

    // R11: a fault leaves both flags set and the walker idle
    assert_fault_flags_R11: assert property (@(posedge clk) disable iff (rst)
        evt.fault |=> (irq_q && err_q && !busy));

    // R8: an abort drops activity on the next cycle
    assert_halt_idle_R8: assert property (@(posedge clk) disable iff (rst)
        halt |=> !busy);

endmodule

// File: rtl/prd_walker.sv
module prd_walker
    import prd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [31:0]       csr_wdata,
    output logic [7:0]        cmd_q,
    output logic [7:0]        stat_q,
    output logic [ADDR_W-1:0] tbl_ptr_q,
    output logic              irq,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              seg_valid,
    output logic [ADDR_W-1:0] seg_base,
    output logic [CNT_W:0]    seg_bytes,
    output logic              seg_to_mem,
    input  logic              seg_done
);
    logic      launch;
    logic      launch_dir;
    logic      halt;
    logic      busy;
    walk_evt_t evt;

    prd_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk        (clk),
        .rst        (rst),
        .we         (csr_we),
        .sel        (csr_sel),
        .wdata      (csr_wdata),
        .busy       (busy),
        .evt        (evt),
        .launch     (launch),
        .launch_dir (launch_dir),
        .halt       (halt),
        .cmd_q      (cmd_q),
        .stat_q     (stat_q),
        .ptr_q      (tbl_ptr_q)
    );

    prd_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .launch        (launch),
        .launch_dir    (launch_dir),
        .halt          (halt),
        .tbl_ptr       (tbl_ptr_q),
        .busy          (busy),
        .evt           (evt),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .seg_valid     (seg_valid),
        .seg_base      (seg_base),
        .seg_bytes     (seg_bytes),
        .seg_to_mem    (seg_to_mem),
        .seg_done      (seg_done)
    );

    assign irq = stat_q[ST_IRQ];

endmodule

// File: tb/prd_walker_test.sv
module prd_walker_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        csr_we;
    logic [1:0]  csr_sel;
    logic [31:0] csr_wdata;
    logic [7:0]  cmd_q;
    logic [7:0]  stat_q;
    logic [31:0] tbl_ptr_q;
    logic        irq;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        mem_rsp_err;
    logic        seg_valid;
    logic [31:0] seg_base;
    logic [16:0] seg_bytes;
    logic        seg_to_mem;
    logic        seg_done;

    always #5 clk = ~clk;

    prd_walker #(.ADDR_W(32), .CNT_W(16)) uut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .cmd_q(cmd_q), .stat_q(stat_q), .tbl_ptr_q(tbl_ptr_q), .irq(irq),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .seg_valid(seg_valid), .seg_base(seg_base), .seg_bytes(seg_bytes),
        .seg_to_mem(seg_to_mem), .seg_done(seg_done)
    );

    typedef struct packed {
        logic [31:0] base;
        logic [16:0] len;
        logic        dir;
    } seg_t;

    int          n_cmp = 0;
    int          n_bad = 0;
    seg_t        seg_exp[$];
    logic [31:0] addr_exp[$];
    logic [31:0] mem [logic [31:0]];
    logic [31:0] bad_addr = 32'hFFFF_FFFF;
    int          rsp_lat = 0;
    bit          stall_mode = 1'b0;
    int          seg_delay = 1;
    bit          cur_dir = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model and fetch-address scoreboard
    initial begin
        int          lat;
        int          cyc;
        bit          pend;
        logic [31:0] paddr;
        lat = 0; cyc = 0; pend = 1'b0; paddr = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend) begin
                mem_req_ready = 1'b0;
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem.exists(paddr) ? mem[paddr] : 32'h0;
                    mem_rsp_err   = (paddr == bad_addr);
                    pend = 1'b0;
                end else begin
                    lat--;
                end
            end else begin
                mem_req_ready = !(stall_mode && (cyc % 3 == 0));
                if (mem_req_valid && mem_req_ready) begin
                    if (addr_exp.size() == 0) begin
                        n_cmp++; n_bad++;
                        $display("FAIL R2 unexpected fetch: actual=%0h expected=none", mem_req_addr);
                    end else begin
                        check("R2 fetch address", 64'(mem_req_addr), 64'(addr_exp.pop_front()));
                    end
                    pend  = 1'b1;
                    paddr = mem_req_addr;
                    lat   = rsp_lat;
                end
            end
        end
    end

    // data mover model and segment scoreboard
    initial begin
        bit   taken;
        bit   prev;
        int   cnt;
        seg_t got;
        taken = 1'b0; cnt = 0; seg_done = 1'b0;
        forever begin
            @(negedge clk);
            prev     = seg_done;
            seg_done = 1'b0;
            if (taken) begin
                if (cnt <= 0) begin
                    seg_done = 1'b1;
                    taken    = 1'b0;
                end else begin
                    cnt--;
                end
            end else if (seg_valid && !prev) begin
                got = {seg_base, seg_bytes, seg_to_mem};
                if (seg_exp.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R3 unexpected segment: actual=%0h expected=none", got);
                end else begin
                    check("R3 segment (R4 zero count)", 64'(got), 64'(seg_exp.pop_front()));
                end
                taken = 1'b1;
                cnt   = seg_delay;
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        csr_sel = s; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] base,
                            input logic [15:0] cnt, input bit last, input bit expect_seg);
        mem[at]        = {last, 15'd0, cnt};
        mem[at + 32'd4] = base;
        addr_exp.push_back(at);
        addr_exp.push_back(at + 32'd4);
        if (expect_seg)
            seg_exp.push_back({base, (cnt == 16'd0) ? 17'h10000 : {1'b0, cnt}, cur_dir});
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!stat_q[0]) break;
        end
    endtask

    task automatic fresh();
        wr(2'd1, 32'h0000_0006);
        wr(2'd0, 32'h0000_0000);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; csr_we = 1'b0; csr_sel = 2'd3; csr_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 status", 64'(stat_q), 64'h0);
        check("R1 command", 64'(cmd_q), 64'h0);
        check("R1 pointer", 64'(tbl_ptr_q), 64'h0);
        check("R1 idle ports", 64'({irq, mem_req_valid, seg_valid}), 64'h0);

        // three-descriptor walk toward memory, with full-window and edge segments
        cur_dir = 1'b1;
        put_desc(32'h1000, 32'h0002_0000, 16'h0200, 1'b0, 1'b1);
        put_desc(32'h1008, 32'h0003_0000, 16'h0000, 1'b0, 1'b1);   // R4
        put_desc(32'h1010, 32'h0004_FF00, 16'h0100, 1'b1, 1'b1);   // R5 exact edge
        wr(2'd2, 32'h0000_1000);
        check("R12 idle pointer write", 64'(tbl_ptr_q), 64'h1000);
        wr(2'd0, 32'h0000_0009);
        check("R7 active after launch", 64'(stat_q[0]), 64'h1);
        check("R7 command byte", 64'(cmd_q), 64'h09);
        wait_idle();
        check("R6 finish status", 64'(stat_q), 64'h04);
        check("R6 irq output", 64'(irq), 64'h1);
        repeat (10) @(negedge clk);
        check("R2 all fetches seen", 64'(addr_exp.size()), 64'h0);
        check("R6 all segments seen", 64'(seg_exp.size()), 64'h0);

        // R9 status write semantics
        wr(2'd1, 32'h0000_0064);
        check("R9 irq cleared, caps loaded", 64'(stat_q), 64'h60);
        wr(2'd1, 32'h0000_0061);
        check("R9 active not writable", 64'(stat_q), 64'h60);
        wr(2'd1, 32'h0000_0000);
        check("R9 caps cleared", 64'(stat_q), 64'h00);

        // R7 no relaunch while run bit still set
        wr(2'd0, 32'h0000_0009);
        repeat (5) @(negedge clk);
        check("R7 no relaunch", 64'(stat_q[0]), 64'h0);

        // stalled, slow fetch toward the device side
        wr(2'd0, 32'h0000_0000);
        cur_dir = 1'b0; stall_mode = 1'b1; rsp_lat = 3; seg_delay = 4;
        put_desc(32'h2000, 32'h0010_0040, 16'h0FC0, 1'b0, 1'b1);
        put_desc(32'h2008, 32'h0010_8000, 16'h0001, 1'b1, 1'b1);
        wr(2'd2, 32'h0000_2000);
        wr(2'd0, 32'h0000_0001);
        wr(2'd2, 32'h5555_0000);
        check("R12 pointer held during run", 64'(tbl_ptr_q), 64'h2000);
        wait_idle();
        check("R3 second walk finish", 64'(stat_q), 64'h04);
        repeat (10) @(negedge clk);
        check("R3 second walk drained", 64'(seg_exp.size() + addr_exp.size()), 64'h0);
        stall_mode = 1'b0; rsp_lat = 0; seg_delay = 1;

        // R5 boundary overrun
        fresh();
        put_desc(32'h3000, 32'h0001_FFF0, 16'h0020, 1'b1, 1'b0);
        wr(2'd2, 32'h0000_3000);
        wr(2'd0, 32'h0000_0001);
        wait_idle();
        check("R5 overrun status", 64'(stat_q), 64'h06);
        check("R5 overrun irq", 64'(irq), 64'h1);

        // R4 zero count with offset base overruns
        fresh();
        put_desc(32'h3010, 32'h0002_0010, 16'h0000, 1'b1, 1'b0);
        wr(2'd2, 32'h0000_3010);
        wr(2'd0, 32'h0000_0001);
        wait_idle();
        check("R4 zero count offset status", 64'(stat_q), 64'h06);

        // R11 bus error on the address word
        fresh();
        mem[32'h4000] = 32'h0000_0010;
        bad_addr = 32'h4004;
        addr_exp.push_back(32'h4000);
        addr_exp.push_back(32'h4004);
        wr(2'd2, 32'h0000_4000);
        wr(2'd0, 32'h0000_0001);
        wait_idle();
        check("R11 bus error status", 64'(stat_q), 64'h06);
        check("R11 fetches seen", 64'(addr_exp.size()), 64'h0);
        bad_addr = 32'hFFFF_FFFF;

        // R10 misaligned pointer
        fresh();
        wr(2'd2, 32'h0000_5002);
        wr(2'd0, 32'h0000_0001);
        check("R10 error only", 64'(stat_q), 64'h02);
        repeat (5) @(negedge clk);
        check("R10 still quiet", 64'({irq, stat_q[0], mem_req_valid}), 64'h0);

        // R8 abort during a segment
        fresh();
        seg_delay = 40;
        put_desc(32'h6000, 32'h7000_0000, 16'h0080, 1'b0, 1'b1);
        wr(2'd2, 32'h0000_6000);
        wr(2'd0, 32'h0000_0001);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (seg_valid) break;
        end
        repeat (2) @(negedge clk);
        wr(2'd0, 32'h0000_0000);
        check("R8 abort clears active", 64'({stat_q[0], seg_valid}), 64'h0);
        repeat (60) @(negedge clk);
        check("R8 no flags after abort", 64'(stat_q), 64'h00);
        check("R8 nothing further", 64'(addr_exp.size() + seg_exp.size()), 64'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule